// File: doc/BRIEF.md
# Column-to-Row Bit Transposer

This block turns a group of packed six-bit column codes into bit rows. Its input is three 48-bit words, which it treats as one 144-bit string. Word 0 sits at the top of that string. The string is read as 24 columns of six bits each, taken in order from the most significant end.

The block regroups these bits into six rows of 24 bits. A given row holds the same bit offset, counted from the top, of every column, and the columns appear in order. The six rows are packed two per output word, so the three output words hold all six rows.

A caller places the three input words on the bus and raises a one-cycle start. On the next clock edge the block registers all three output words and raises a one-cycle done. The outputs then keep their values until the next start.

Top module: `colrow_transposer`

## Requirements
- R1: While reset is asserted and after it is released, done is 0 and all output bits are 0 until the first start is taken.
- R2: done is 1 in exactly the cycle after a clock edge that sampled start high, and it is 0 in every other cycle.
- R3: When start is low at a clock edge, the output words do not change.
- R4: The most significant bit of input word 0 appears as the most significant bit of output word 0.
- R5: The top 24 output bits (row 0, upper half of output word 0) are input bits 143, 137, 131, … 5 of the 144-bit input string, in that order. That is every sixth bit, starting from the most significant.
- R6: Output bit 25 counted from the top (flat bit 119) is the second most significant bit of input word 0. In general, row r holds offset r of each column, so flat output bit 143-(24r+c) equals flat input bit 143-(6c+r).
- R7: Rows 0 and 1 occupy the upper and lower halves of output word 0. Rows 2 and 3 fill word 1, and rows 4 and 5 fill word 2. Word 0 is flat bits 143:96 and word 2 is flat bits 47:0, on both buses.
- R8: Applying the inverse mapping to the output words gives back exactly the input words that were sampled with start.
- R9: When start is high on back-to-back cycles, each start produces the result for the words sampled with it, one cycle later.
- R10: The number of ones in the output words equals the number of ones in the input words sampled with start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Samples the input words and begins a conversion |
| col_words_i | input | 144 | Three column-packed words; word 0 in bits 143:96 |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| row_words_o | output | 144 | Three row-packed words; word 0 in bits 143:96 |

## Verification
Several properties are checked on every cycle after each start: that done follows start by exactly one cycle, that the outputs stay put when start is low, that the top bit passes straight through, that the inverse mapping round-trips, and that the number of ones is preserved. The bench covers what a single-cycle property cannot show. It sets single bits in chosen columns and offsets to confirm the positions of rows 0, 1 and 5, checks the reset contents, and feeds back-to-back starts with different words. It also checks random inputs against a bench model of the gather.

// File: rtl/colrow_pkg.sv
package colrow_pkg;

   // Flat index of the input bit at offset `row` of column `col`.
   function automatic int cr_src_bit(input int total_w, input int col_w,
                                     input int row, input int col);
      return total_w - 1 - (col * col_w + row);
   endfunction

   // Flat index of the output bit at position `col` of row `row`.
   function automatic int cr_dst_bit(input int total_w, input int num_cols,
                                     input int row, input int col);
      return total_w - 1 - (row * num_cols + col);
   endfunction

endpackage

// File: rtl/colrow_gather.sv
module colrow_gather #(
   parameter int TOTAL_W = 144,
   parameter int COL_W   = 6
) (
   input  logic [TOTAL_W-1:0] cols_i,
   output logic [TOTAL_W-1:0] rows_o
);
   import colrow_pkg::*;

   localparam int NUM_COLS = TOTAL_W / COL_W;

   for (genvar r = 0; r < COL_W; r++) begin : g_row
      for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
         assign rows_o[cr_dst_bit(TOTAL_W, NUM_COLS, r, c)] =
                cols_i[cr_src_bit(TOTAL_W, COL_W, r, c)];
      end
   end

endmodule

// File: rtl/colrow_hold_reg.sv
module colrow_hold_reg #(
   parameter int W = 144
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o <= '0;
      else if (load_i) q_o <= d_i;
   end
endmodule

// File: rtl/colrow_ctrl.sv
module colrow_ctrl (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic done_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) done_o <= 1'b0;
      else         done_o <= start_i;
   end
endmodule

// File: rtl/colrow_transposer.sv
module colrow_transposer #(
   parameter int WORD_W    = 48,
   parameter int COL_W     = 6,
   parameter int NUM_WORDS = 3
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        start_i,
   input  logic [NUM_WORDS*WORD_W-1:0] col_words_i,
   output logic                        done_o,
   output logic [NUM_WORDS*WORD_W-1:0] row_words_o
);
   localparam int TOTAL_W  = NUM_WORDS * WORD_W;
   localparam int NUM_COLS = TOTAL_W / COL_W;

   initial begin
      assert (WORD_W % COL_W == 0)
         else $error("colrow_transposer: columns must not straddle words");
      assert (NUM_COLS > 0 && COL_W > 0)
         else $error("colrow_transposer: empty geometry");
   end

   logic [TOTAL_W-1:0] gathered;

   colrow_gather #(.TOTAL_W(TOTAL_W), .COL_W(COL_W)) gather_i (
      .cols_i (col_words_i),
      .rows_o (gathered)
   );

   colrow_hold_reg #(.W(TOTAL_W)) hold_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (start_i),
      .d_i    (gathered),
      .q_o    (row_words_o)
   );

   colrow_ctrl ctrl_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_i),
      .done_o  (done_o)
   );

endmodule

// File: rtl/colrow_transposer_chk.sv
module colrow_transposer_chk #(
   parameter int TOTAL_W = 144,
   parameter int COL_W   = 6
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               start_i,
   input logic [TOTAL_W-1:0] col_words_i,
   input logic               done_o,
   input logic [TOTAL_W-1:0] row_words_o
);
   import colrow_pkg::*;

   localparam int NUM_COLS = TOTAL_W / COL_W;

   function automatic logic [TOTAL_W-1:0] undo(input logic [TOTAL_W-1:0] rows);
      logic [TOTAL_W-1:0] cols;
      cols = '0;
      for (int c = 0; c < NUM_COLS; c++)
         for (int r = 0; r < COL_W; r++)
            cols[cr_src_bit(TOTAL_W, COL_W, r, c)] =
               rows[cr_dst_bit(TOTAL_W, NUM_COLS, r, c)];
      return cols;
   endfunction

   assert_done_follows_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> done_o);
   assert_no_stray_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> !done_o);
   assert_hold_when_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> $stable(row_words_o));
   assert_top_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> row_words_o[TOTAL_W-1] == $past(col_words_i[TOTAL_W-1]));
   assert_round_trip_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> undo(row_words_o) == $past(col_words_i));
   assert_ones_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> $countones(row_words_o) == $countones($past(col_words_i)));

endmodule

bind colrow_transposer colrow_transposer_chk #(.TOTAL_W(TOTAL_W), .COL_W(COL_W)) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .start_i     (start_i),
   .col_words_i (col_words_i),
   .done_o      (done_o),
   .row_words_o (row_words_o)
);

// File: tb/colrow_transposer_tb_top.sv
`timescale 1ns/1ps
module colrow_transposer_tb_top;
   localparam int T  = 144;
   localparam int CW = 6;
   localparam int NC = T / CW;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [T-1:0] cols = '0;
   logic         done;
   logic [T-1:0] rows;
   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   colrow_transposer dut_i (
      .clk_i (clk), .rst_ni (rst_n), .start_i (start),
      .col_words_i (cols), .done_o (done), .row_words_o (rows)
   );

   function automatic logic [T-1:0] model(input logic [T-1:0] x);
      logic [T-1:0] y = '0;
      for (int r = 0; r < CW; r++)
         for (int c = 0; c < NC; c++)
            y[T-1-(r*NC+c)] = x[T-1-(c*CW+r)];
      return y;
   endfunction

   function automatic logic [T-1:0] unmodel(input logic [T-1:0] y);
      logic [T-1:0] x = '0;
      for (int k = 0; k < T; k++)
         x[T-1-k] = y[T-1-((k % CW)*NC + k / CW)];
      return x;
   endfunction

   function automatic logic [T-1:0] rnd();
      return {$urandom, $urandom, $urandom, $urandom, $urandom};
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [T-1:0] act, input logic [T-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_one(input logic [T-1:0] x, input string req);
      logic [T-1:0] e;
      e = model(x);
      cols = x; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done === 1'b1, "R2 done after start", T'(done), T'(1));
      chk(rows === e, req, rows, e);
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      bad++; total++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [T-1:0] x, y, held;
      void'($urandom(32'd2024));
      @(negedge clk);
      chk(done === 1'b0 && rows === '0, "R1 in reset", rows, '0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk(done === 1'b0, "R1 done after reset", T'(done), '0);
      chk(rows === '0, "R1 rows after reset", rows, '0);

      // R4: single top bit
      x = '0; x[T-1] = 1'b1;
      run_one(x, "R4 top bit");
      chk(rows[T-1] === 1'b1 && $countones(rows) == 1, "R4 only top bit", rows, x);

      // R5: top bit of every column gives row 0 all ones
      x = '0;
      for (int c = 0; c < NC; c++) x[T-1-c*CW] = 1'b1;
      run_one(x, "R5 row0 gather");
      chk(rows[T-1 -: 24] === 24'hFFFFFF && rows[T-25:0] === '0, "R5 row0 field", rows, model(x));

      // R6: second bit of word 0 goes to output bit 119
      x = '0; x[T-2] = 1'b1;
      run_one(x, "R6 second bit");
      chk(rows[119] === 1'b1, "R6 bit 25 from top", rows, model(x));

      // R7: last bit of every column fills low half of word 2
      x = '0;
      for (int c = 0; c < NC; c++) x[T-1-c*CW-5] = 1'b1;
      run_one(x, "R7 row5");
      chk(rows[23:0] === 24'hFFFFFF && rows[T-1:24] === '0, "R7 row5 in word2 low", rows, model(x));

      // R7: offset 1 of every column fills low half of word 0
      x = '0;
      for (int c = 0; c < NC; c++) x[T-1-c*CW-1] = 1'b1;
      run_one(x, "R7 row1");
      chk(rows[119:96] === 24'hFFFFFF, "R7 row1 in word0 low", rows, model(x));

      // R3: idle cycles keep the result even when inputs change
      held = rows;
      for (int i = 0; i < 3; i++) begin
         cols = rnd();
         @(negedge clk);
         chk(rows === held, "R3 hold", rows, held);
         chk(done === 1'b0, "R2 no done when idle", T'(done), '0);
      end

      // R9: back-to-back starts
      x = rnd(); y = rnd();
      cols = x; start = 1'b1;
      @(negedge clk);
      chk(rows === model(x), "R9 first of pair", rows, model(x));
      cols = y;
      @(negedge clk);
      start = 1'b0;
      chk(done === 1'b1, "R9 done on second", T'(done), T'(1));
      chk(rows === model(y), "R9 second of pair", rows, model(y));

      // Random: R5/R6 via model, R8 round trip, R10 ones count
      for (int i = 0; i < 200; i++) begin
         x = rnd();
         run_one(x, "R6 random gather");
         chk(unmodel(rows) === x, "R8 inverse", unmodel(rows), x);
         chk($countones(rows) == $countones(x), "R10 ones count",
             T'($countones(rows)), T'($countones(x)));
         @(negedge clk);
      end

      // all ones and all zeros corners
      run_one('1, "R5 all ones");
      run_one('0, "R5 all zeros");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule